// File: doc/BRIEF.md
# Parallel LWE Matrix MAC Engine

This engine forms one row of the learning-with-errors product C = S'·A + E', where S' is a secret row vector of length INNER, A is an INNER x COLS matrix of 16-bit elements and E' is an error row of length COLS. The matrix A is never held in the block. It arrives on the fly from LANES/2 pseudorandom streams, and each stream delivers a 32-bit word per beat. Every word is cut into two 16-bit elements, so LANES elements of one row of A are consumed per beat. Each lane owns the output columns whose index is congruent to its lane number modulo LANES, which gives a LANES-fold gain in multiply throughput over one lane.

A run starts with a start pulse. The engine first loads its accumulators from E', one group of LANES columns per cycle. It then walks A row by row, in column groups of LANES, and adds the product of the current S' element and each A element in wrapping 16-bit arithmetic. A beat is taken only when every stream is valid, so all lanes stall together and stay aligned. After the last row, the results leave one column per cycle in ascending order, reduced to Q_BITS bits, and a done pulse follows. Several rows of C are obtained by repeated runs with the same stream seed.

Top module: `lwe_mac_engine`

## Requirements
- R1: After reset, c_valid, done and rnd_ready are all low.
- R2: start is acted on only while the engine is idle; a start pulse during a run does not alter its results or add a second done pulse.
- R3: Before any product, the accumulator of column c is loaded with E'[c], taken from e_data bits [16*(c mod LANES) +: 16] while e_grp equals c / LANES; with S' all zero, the output is E' reduced.
- R4: Stream t carries its word on rnd_data[32*t +: 32]; its low half is element 2t and its high half element 2t+1 of the current column group, i.e. column g*LANES + 2t (+1) of the current row.
- R5: During the products, s_row gives the row index i of A being consumed and s_data (same cycle, S'[i]) multiplies every element of that row.
- R6: Each result equals (E'[c] + sum over i of S'[i]*A[i][c]) with all sums and products taken modulo 2^16, then masked to its low Q_BITS bits.
- R7: A beat is consumed only in a cycle where rnd_ready is high and all rnd_valid bits are high; otherwise s_row and rnd_ready hold and no accumulator changes.
- R8: After the final beat, c_valid is high for COLS consecutive cycles with c_col running 0, 1, ..., COLS-1 and c_data the matching result.
- R9: done is a single-cycle pulse in the cycle right after the last output (c_col = COLS-1).
- R10: rnd_ready is high only while products are being taken, never together with c_valid or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the engine is idle |
| s_row | output | $clog2(INNER) | Index of the S' element needed this cycle |
| s_data | input | 16 | S'[s_row], valid in the same cycle |
| e_grp | output | $clog2(COLS/LANES) | Column group of E' being loaded |
| e_data | input | 16*LANES | E' elements of group e_grp, lane j in bits [16j +: 16] |
| rnd_valid | input | LANES/2 | Per-stream word valid |
| rnd_data | input | 16*LANES | Stream words, stream t in bits [32t +: 32] |
| rnd_ready | output | 1 | Engine takes a beat when all streams are valid |
| c_valid | output | 1 | Result element valid |
| c_col | output | $clog2(COLS) | Column index of c_data |
| c_data | output | 16 | Result element, reduced to Q_BITS bits |
| done | output | 1 | One-cycle pulse after the last result |

## Verification
The bench builds the engine with LANES = 4 (two streams), INNER = 6, COLS = 12 and Q_BITS = 15. Three column groups make the group counter wrap at a value that is not a power of two, and the short inner dimension keeps each run near twenty beats so that random stalls on each stream separately, a stray start in mid-run and an all-ones wrap case all fit. The 15-bit mask lets the top bit of E' and of the sums show whether the reduction is applied.

// File: rtl/lwe_mac_pkg.sv
package lwe_mac_pkg;

  localparam int ELEM_W = 16;
  localparam int WORD_W = 32;

  typedef logic [ELEM_W-1:0] elem_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_MAC,
    PH_EMIT,
    PH_DONE
  } phase_e;

  // acc + a*s, everything wrapping modulo 2^16
  function automatic elem_t mac16(elem_t acc, elem_t a, elem_t s);
    logic [2*ELEM_W-1:0] prod;
    prod = a * s;
    return acc + prod[ELEM_W-1:0];
  endfunction

  // keep only the low qbits bits of v
  function automatic elem_t reduce_q(elem_t v, int qbits);
    elem_t r;
    for (int b = 0; b < ELEM_W; b++) begin
      r[b] = (b < qbits) ? v[b] : 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/lwe_mac_split.sv
module lwe_mac_split
  import lwe_mac_pkg::*;
#(
  parameter int LANES   = 4,
  localparam int STREAMS = LANES / 2
) (
  input  logic [STREAMS-1:0]              rnd_valid,
  input  logic [STREAMS*WORD_W-1:0]       rnd_data,
  output logic                            all_valid,
  output logic [LANES-1:0][ELEM_W-1:0]    lane_a
);

  assign all_valid = &rnd_valid;

  for (genvar t = 0; t < STREAMS; t++) begin : g_stream
    logic [WORD_W-1:0] word;
    assign word             = rnd_data[t*WORD_W +: WORD_W];
    assign lane_a[2*t]      = word[ELEM_W-1:0];
    assign lane_a[2*t + 1]  = word[WORD_W-1:ELEM_W];
  end

endmodule

// File: rtl/lwe_mac_lane.sv
module lwe_mac_lane
  import lwe_mac_pkg::*;
#(
  parameter int GROUPS = 4,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          mac_en,
  input  logic [GW-1:0] wr_grp,
  input  elem_t         e_val,
  input  elem_t         a_val,
  input  elem_t         s_val,
  input  logic [GW-1:0] rd_grp,
  output elem_t         rd_val
);

  elem_t bank [GROUPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < GROUPS; g++) bank[g] <= '0;
    end else if (ld_en) begin
      bank[wr_grp] <= e_val;
    end else if (mac_en) begin
      bank[wr_grp] <= mac16(bank[wr_grp], a_val, s_val);
    end
  end

  assign rd_val = bank[rd_grp];

endmodule

// File: rtl/lwe_mac_ctrl.sv
module lwe_mac_ctrl
  import lwe_mac_pkg::*;
#(
  parameter int INNER  = 8,
  parameter int COLS   = 16,
  parameter int GROUPS = 4,
  localparam int RW = (INNER  > 1) ? $clog2(INNER)  : 1,
  localparam int CW = (COLS   > 1) ? $clog2(COLS)   : 1,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          all_valid,
  output logic [GW-1:0] grp_idx,
  output logic [RW-1:0] row_idx,
  output logic [CW-1:0] col_idx,
  output logic          ld_en,
  output logic          mac_en,
  output logic          emit_en,
  output logic          in_mac,
  output logic          done_q
);

  localparam logic [GW-1:0] GRP_LAST = GW'(GROUPS - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(INNER - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  phase_e phase;

  assign ld_en   = (phase == PH_LOAD);
  assign in_mac  = (phase == PH_MAC);
  assign mac_en  = in_mac && all_valid;
  assign emit_en = (phase == PH_EMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      grp_idx <= '0;
      row_idx <= '0;
      col_idx <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (phase == PH_DONE);
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_LOAD;
            grp_idx <= '0;
          end
        end
        PH_LOAD: begin
          if (grp_idx == GRP_LAST) begin
            grp_idx <= '0;
            row_idx <= '0;
            phase   <= PH_MAC;
          end else begin
            grp_idx <= grp_idx + 1'b1;
          end
        end
        PH_MAC: begin
          if (all_valid) begin
            if (grp_idx == GRP_LAST) begin
              grp_idx <= '0;
              if (row_idx == ROW_LAST) begin
                col_idx <= '0;
                phase   <= PH_EMIT;
              end else begin
                row_idx <= row_idx + 1'b1;
              end
            end else begin
              grp_idx <= grp_idx + 1'b1;
            end
          end
        end
        PH_EMIT: begin
          if (col_idx == COL_LAST) phase <= PH_DONE;
          else                     col_idx <= col_idx + 1'b1;
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lwe_mac_engine.sv
module lwe_mac_engine
  import lwe_mac_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int INNER  = 8,
  parameter int COLS   = 16,
  parameter int Q_BITS = 15,
  localparam int STREAMS = LANES / 2,
  localparam int GROUPS  = COLS / LANES,
  localparam int LB = $clog2(LANES),
  localparam int RW = (INNER  > 1) ? $clog2(INNER)  : 1,
  localparam int CW = (COLS   > 1) ? $clog2(COLS)   : 1,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  output logic [RW-1:0]             s_row,
  input  logic [ELEM_W-1:0]         s_data,
  output logic [GW-1:0]             e_grp,
  input  logic [LANES*ELEM_W-1:0]   e_data,
  input  logic [STREAMS-1:0]        rnd_valid,
  input  logic [STREAMS*WORD_W-1:0] rnd_data,
  output logic                      rnd_ready,
  output logic                      c_valid,
  output logic [CW-1:0]             c_col,
  output logic [ELEM_W-1:0]         c_data,
  output logic                      done
);

  // named internal events, also used by the bound checker
  logic                         all_valid;
  logic                         beat_fire;
  logic                         load_fire;
  logic                         emit_fire;
  logic [GW-1:0]                grp_idx;
  logic [RW-1:0]                row_idx;
  logic [CW-1:0]                col_idx;
  logic [LANES-1:0][ELEM_W-1:0] lane_a;
  logic [LANES-1:0][ELEM_W-1:0] lane_rd;
  logic [GW-1:0]                rd_grp;
  logic [LB-1:0]                rd_lane;
  logic                         done_q;

  lwe_mac_split #(.LANES(LANES)) u_split (
    .rnd_valid (rnd_valid),
    .rnd_data  (rnd_data),
    .all_valid (all_valid),
    .lane_a    (lane_a)
  );

  lwe_mac_ctrl #(.INNER(INNER), .COLS(COLS), .GROUPS(GROUPS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .all_valid (all_valid),
    .grp_idx   (grp_idx),
    .row_idx   (row_idx),
    .col_idx   (col_idx),
    .ld_en     (load_fire),
    .mac_en    (beat_fire),
    .emit_en   (emit_fire),
    .in_mac    (rnd_ready),
    .done_q    (done_q)
  );

  assign s_row   = row_idx;
  assign e_grp   = grp_idx;
  assign rd_grp  = GW'(col_idx >> LB);
  assign rd_lane = col_idx[LB-1:0];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    lwe_mac_lane #(.GROUPS(GROUPS)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_en  (load_fire),
      .mac_en (beat_fire),
      .wr_grp (grp_idx),
      .e_val  (e_data[j*ELEM_W +: ELEM_W]),
      .a_val  (lane_a[j]),
      .s_val  (s_data),
      .rd_grp (rd_grp),
      .rd_val (lane_rd[j])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_valid <= 1'b0;
      c_col   <= '0;
      c_data  <= '0;
    end else begin
      c_valid <= emit_fire;
      if (emit_fire) begin
        c_col  <= col_idx;
        c_data <= reduce_q(lane_rd[rd_lane], Q_BITS);
      end
    end
  end

  assign done = done_q;

endmodule

// File: rtl/lwe_mac_engine_chk.sv
module lwe_mac_engine_chk #(
  parameter int COLS    = 16,
  parameter int STREAMS = 2,
  parameter int RW      = 3,
  parameter int CW      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [STREAMS-1:0] rnd_valid,
  input logic               rnd_ready,
  input logic [RW-1:0]      s_row,
  input logic               beat_fire,
  input logic               c_valid,
  input logic [CW-1:0]      c_col,
  input logic               done
);

  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  // R9: done follows the last output by exactly one cycle
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && c_col == COL_LAST) |=> done);

  // R9: done lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: columns leave in ascending consecutive order
  a_r8_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && c_col != COL_LAST) |=> (c_valid && c_col == CW'($past(c_col) + 1'b1)));

  // R8: the output burst starts at column zero
  a_r8_first_col: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_valid) |-> (c_col == '0));

  // R10: the stream side is never open while results or done are out
  a_r10_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_ready |-> (!c_valid && !done));

  // R7: a stalled cycle holds the row index and keeps the engine waiting
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_ready && !(&rnd_valid)) |=> (rnd_ready && $stable(s_row)));

  // R7: no beat is taken without every stream valid
  a_r7_beat_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |-> (&rnd_valid));

endmodule

bind lwe_mac_engine lwe_mac_engine_chk #(
  .COLS(COLS), .STREAMS(STREAMS), .RW(RW), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rnd_valid (rnd_valid),
  .rnd_ready (rnd_ready),
  .s_row     (s_row),
  .beat_fire (beat_fire),
  .c_valid   (c_valid),
  .c_col     (c_col),
  .done      (done)
);

// File: tb/lwe_mac_engine_bench.sv
`timescale 1ns/1ps
module lwe_mac_engine_bench;

  localparam int LANES   = 4;
  localparam int INNER   = 6;
  localparam int COLS    = 12;
  localparam int QB      = 15;
  localparam int STREAMS = LANES / 2;
  localparam int GROUPS  = COLS / LANES;
  localparam int NBEATS  = INNER * GROUPS;
  localparam int RW = $clog2(INNER);
  localparam int CW = $clog2(COLS);
  localparam int GW = $clog2(GROUPS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [RW-1:0] s_row;
  logic [15:0] s_data;
  logic [GW-1:0] e_grp;
  logic [LANES*16-1:0] e_data;
  logic [STREAMS-1:0] rnd_valid = '0;
  logic [STREAMS*32-1:0] rnd_data = '0;
  logic rnd_ready, c_valid, done;
  logic [CW-1:0] c_col;
  logic [15:0] c_data;

  always #2.5 clk = ~clk;

  lwe_mac_engine #(.LANES(LANES), .INNER(INNER), .COLS(COLS), .Q_BITS(QB)) u_lwe_mac_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .s_row(s_row), .s_data(s_data),
    .e_grp(e_grp), .e_data(e_data), .rnd_valid(rnd_valid), .rnd_data(rnd_data),
    .rnd_ready(rnd_ready), .c_valid(c_valid), .c_col(c_col), .c_data(c_data), .done(done)
  );

  logic [15:0] s_mem [INNER];
  logic [15:0] e_mem [COLS];
  logic [15:0] a_mem [INNER][COLS];
  logic [15:0] got   [COLS];

  // host-side memories answer in the same cycle
  always_comb begin
    s_data = (int'(s_row) < INNER) ? s_mem[s_row] : 16'h0;
    for (int j = 0; j < LANES; j++) begin
      int idx;
      idx = int'(e_grp) * LANES + j;
      e_data[j*16 +: 16] = (idx < COLS) ? e_mem[idx] : 16'h0;
    end
  end

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_col, order_err, done_cnt, done_cyc, last_cyc;

  always @(posedge clk) cyc <= cyc + 1;

  // output monitor
  always @(negedge clk) begin
    if (c_valid) begin
      if (int'(c_col) != exp_col) order_err++;
      if (int'(c_col) < COLS) got[c_col] = c_data;
      exp_col++;
      last_cyc = cyc;
    end
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // one full run; stall: random per-stream gaps; glitch: stray start mid-run
  task automatic run_case(input string req, input bit stall, input bit glitch);
    logic [15:0] expv [COLS];
    int beat;
    int stall_err;
    bit will;
    bit waited;
    logic [RW-1:0] row_before;
    for (int c = 0; c < COLS; c++) begin
      logic [15:0] acc;
      acc = e_mem[c];
      for (int i = 0; i < INNER; i++) begin
        logic [31:0] p;
        p = 32'(s_mem[i]) * 32'(a_mem[i][c]);
        acc = acc + p[15:0];
      end
      expv[c] = acc & 16'h7FFF;
    end
    exp_col = 0; order_err = 0; done_cnt = 0; stall_err = 0; waited = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    beat = 0;
    while (beat < NBEATS) begin
      @(negedge clk);
      for (int t = 0; t < STREAMS; t++) begin
        int i, g;
        i = beat / GROUPS;
        g = beat % GROUPS;
        rnd_data[t*32 +: 32] = {a_mem[i][g*LANES + 2*t + 1], a_mem[i][g*LANES + 2*t]};
        rnd_valid[t] = stall ? (($urandom % 3) != 0) : 1'b1;
      end
      start = glitch && (beat == 3);
      #1;
      will = rnd_ready && (&rnd_valid);
      row_before = s_row;
      if (rnd_ready && !(&rnd_valid)) waited = 1;
      @(posedge clk);
      #1;
      if (rnd_ready && !will && beat > 0 && s_row != row_before) stall_err++;
      if (will) beat++;
    end
    @(negedge clk);
    rnd_valid = '0;
    start = 1'b0;
    for (int w = 0; w < 100 && done_cnt == 0; w++) @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < COLS; c++)
      chk(got[c] == expv[c], req, int'(got[c]), int'(expv[c]));
    chk(order_err == 0, "R8 column order", order_err, 0);
    chk(exp_col == COLS, "R8 output count", exp_col, COLS);
    chk(done_cnt == 1, "R9 done count (R2 no extra run)", done_cnt, 1);
    chk(done_cyc == last_cyc + 1, "R9 done timing", done_cyc, last_cyc + 1);
    chk(rnd_ready == 1'b0, "R10 ready low after run", int'(rnd_ready), 0);
    if (stall) begin
      chk(waited, "R7 stall exercised", int'(waited), 1);
      chk(stall_err == 0, "R7 row held in stall", stall_err, 0);
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < INNER; i++) begin
      s_mem[i] = 16'($urandom);
      for (int c = 0; c < COLS; c++) a_mem[i][c] = 16'($urandom);
    end
    for (int c = 0; c < COLS; c++) e_mem[c] = 16'($urandom);
  endtask

  task automatic t_reset();
    chk(c_valid == 1'b0, "R1 c_valid", int'(c_valid), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(rnd_ready == 1'b0, "R1 rnd_ready", int'(rnd_ready), 0);
  endtask

  task automatic t_random();
    fill_random();
    run_case("R4 R5 R6 random", 1'b0, 1'b0);
  endtask

  task automatic t_stall();
    fill_random();
    run_case("R7 stalled result", 1'b1, 1'b0);
  endtask

  task automatic t_zero_s();
    fill_random();
    for (int i = 0; i < INNER; i++) s_mem[i] = 16'h0;
    for (int c = 0; c < COLS; c++) e_mem[c] = 16'h8000 | 16'(c * 977);
    run_case("R3 E preload", 1'b0, 1'b0);
  endtask

  task automatic t_one_row();
    fill_random();
    for (int i = 0; i < INNER; i++) s_mem[i] = (i == 2) ? 16'h1 : 16'h0;
    for (int c = 0; c < COLS; c++) e_mem[c] = 16'h0;
    run_case("R4 R5 lane split of one row", 1'b0, 1'b0);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < INNER; i++) begin
      s_mem[i] = 16'hFFFF;
      for (int c = 0; c < COLS; c++) a_mem[i][c] = 16'hFFFF;
    end
    for (int c = 0; c < COLS; c++) e_mem[c] = 16'hFFFF;
    run_case("R6 wrap all ones", 1'b0, 1'b0);
    chk(got[0] == 16'h0005, "R6 wrap value", int'(got[0]), 5);
  endtask

  task automatic t_glitch();
    fill_random();
    run_case("R2 start ignored while busy", 1'b1, 1'b1);
  endtask

  initial begin
    for (int c = 0; c < COLS; c++) got[c] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_random();
    t_stall();
    t_zero_s();
    t_one_row();
    t_wrap();
    t_glitch();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule